// File: doc/BRIEF.md
# PWM Trip Flag and Interrupt Controller

This block keeps the protection state of one PWM channel. It has two trip latches and four digital-compare event flags. One latch is cleared on every PWM cycle and the other is sticky. Each latch or flag is set by its own single-cycle input strobe. The timebase, the comparators and the output forcing logic sit outside the block; they only supply strobes to it.

Software clears flags through a write-1-to-clear register. The same register also appears at a mirror address. A 2-bit field in that register selects which timebase strobe clears the per-cycle latch automatically: counter-at-zero, counter-at-period, either of the two, or neither.

A global interrupt flag summarises the trip and event flags. The block raises a one-cycle interrupt pulse each time the global flag goes from clear to set. A read-only status address shows every flag.

Top module: `pwm_trip_flag_ctrl`

## Requirements
- R1: After reset, all flags and latches are clear, the clear-source select reads 00, every address reads 0 and `irq_o` is low.
- R2: A strobe on a trip or event input sets its flag on the next clock edge. Status (address 0) bit positions are: bit 0 global, bit 1 per-cycle latch, bit 2 one-shot latch, bits 3..6 events in `dc_evt_i` index order. Bits 15..7 read 0.
- R3: A write to a clear address (1 or 2) with bit k = 1 clears the flag at status bit k. Writing 0 in a clear bit changes nothing. On a read of a clear address, bits 13..0 are always 0.
- R4: The mirror address 2 behaves the same as address 1 for both clearing and the select field.
- R5: The select field sits in bits 15..14 of either clear address. It is read/write, is written by every clear-address write, and resets to 00. Its encoding is: 00 means counter-at-zero clears the per-cycle latch, 01 means counter-at-period clears it, 10 means either strobe clears it, 11 means no automatic clear.
- R6: A set strobe wins over a clear (software or automatic) that arrives in the same cycle.
- R7: The global flag sets one cycle after any other flag is set while the global flag is clear. `irq_o` is high for exactly one cycle, the cycle in which the global flag first reads set.
- R8: While the global flag stays set, no further interrupt pulse occurs, even if more flags are set.
- R9: Clearing only the global flag while other flags remain set produces a new pulse. Once all flags are clear, no pulse occurs until a new trip arrives.
- R10: Timebase strobes never clear the one-shot latch or the event flags. With select 11 they never clear the per-cycle latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cbc_trip_i | input | 1 | Set strobe for the per-cycle trip latch |
| ost_trip_i | input | 1 | Set strobe for the one-shot trip latch |
| dc_evt_i | input | 4 | Set strobes for the four digital-compare event flags |
| tb_zero_i | input | 1 | Timebase counter-at-zero strobe |
| tb_prd_i | input | 1 | Timebase counter-at-period strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Write address (1 clear, 2 clear mirror) |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address (0 status, 1/2 clear register) |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | One-cycle trip interrupt pulse |

## Verification
The assertions check several rules on every cycle. They confirm that a set strobe always lands its flag and that an uncontested clear removes it. They confirm that the interrupt pulse lasts one cycle and coincides with the rise of the global flag. They also confirm that a held global flag suppresses pulses, that select 11 never produces an automatic clear, and that the one-shot latch holds unless software clears it.

Some behaviour can only be shown by the bench's scenarios:
- the exact status bit positions;
- the mirror address acting the same as the primary;
- the full sweep of the select codes against the zero/period strobe combinations;
- the re-arming of the interrupt after a global-only clear, and the silence after a full clear.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int NUM_EVT  = 4;
    // latch/flag vector excluding the global flag: cbc, ost, events
    localparam int NUM_FLAG = 2 + NUM_EVT;
    // clear/status vector including the global flag at bit 0
    localparam int CLR_W    = NUM_FLAG + 1;
    localparam int SEL_LSB  = DATA_W - 2;

    localparam int IDX_CBC  = 0;
    localparam int IDX_OST  = 1;
    localparam int IDX_EVT0 = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLR    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CLR_MR = 2'd2;

    typedef enum logic [1:0] {
        SRC_ZERO   = 2'b00,
        SRC_PERIOD = 2'b01,
        SRC_EITHER = 2'b10,
        SRC_NONE   = 2'b11
    } clr_src_e;
endpackage

// File: rtl/ptf_autoclr.sv
module ptf_autoclr
    import ptf_pkg::*;
(
    input  clr_src_e sel_i,
    input  logic     tb_zero_i,
    input  logic     tb_prd_i,
    output logic     clr_o
);
    always_comb begin
        unique case (sel_i)
            SRC_ZERO:   clr_o = tb_zero_i;
            SRC_PERIOD: clr_o = tb_prd_i;
            SRC_EITHER: clr_o = tb_zero_i | tb_prd_i;
            default:    clr_o = 1'b0;
        endcase
    end

    always_comb begin
        if (sel_i == SRC_NONE) begin
            AST_NONE_NO_CLEAR: assert (!clr_o); // R10
        end
    end
endmodule

// File: rtl/ptf_flag_bank.sv
module ptf_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] nxt;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // set dominates any clear in the same cycle
        assign nxt[g] = set_i[g] | (st_q.flag[g] & ~clr_i[g]);

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]); // R6
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]); // R3
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/ptf_regif.sv
module ptf_regif
    import ptf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic                glob_i,
    input  logic [NUM_FLAG-1:0] flag_i,
    output logic [CLR_W-1:0]    sw_clr_o,
    output clr_src_e            sel_o,
    output logic [DATA_W-1:0]   rd_data_o
);
    typedef struct packed {
        clr_src_e sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_hit;

    assign wr_hit = wr_en_i && (wr_addr_i == ADDR_CLR || wr_addr_i == ADDR_CLR_MR);

    always_comb begin
        regs_d   = regs_q;
        sw_clr_o = '0;
        if (wr_hit) begin
            regs_d.sel = clr_src_e'(wr_data_i[DATA_W-1:SEL_LSB]);
            sw_clr_o   = wr_data_i[CLR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{sel: SRC_ZERO};
        else        regs_q <= regs_d;
    end

    assign sel_o = regs_q.sel;

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_STATUS:          rd_data_o = {{(DATA_W-CLR_W){1'b0}}, flag_i, glob_i};
            ADDR_CLR, ADDR_CLR_MR: rd_data_o = {regs_q.sel, {SEL_LSB{1'b0}}};
            default:              rd_data_o = '0;
        endcase
    end

    AST_SEL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (sel_o == $past(wr_data_i[DATA_W-1:SEL_LSB]))); // R5
endmodule

// File: rtl/ptf_irq_gen.sv
module ptf_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic any_flag_i,
    input  logic clr_glob_i,
    output logic glob_o,
    output logic irq_o
);
    typedef struct packed {
        logic glob;
        logic irq;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.glob) begin
            st_d.glob = ~clr_glob_i;
            st_d.irq  = 1'b0;
        end else begin
            st_d.glob = any_flag_i;
            st_d.irq  = any_flag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign glob_o = st_q.glob;
    assign irq_o  = st_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_IRQ_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $rose(glob_o)); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_o && !clr_glob_i) |=> !irq_o); // R8
endmodule

// File: rtl/pwm_trip_flag_ctrl.sv
module pwm_trip_flag_ctrl
    import ptf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cbc_trip_i,
    input  logic               ost_trip_i,
    input  logic [NUM_EVT-1:0] dc_evt_i,
    input  logic               tb_zero_i,
    input  logic               tb_prd_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o
);
    logic [CLR_W-1:0]    sw_clr;
    logic [NUM_FLAG-1:0] set_vec;
    logic [NUM_FLAG-1:0] clr_vec;
    logic [NUM_FLAG-1:0] flags;
    clr_src_e            sel;
    logic                auto_clr;
    logic                glob;

    assign set_vec = {dc_evt_i, ost_trip_i, cbc_trip_i};

    always_comb begin
        clr_vec          = sw_clr[CLR_W-1:1];
        clr_vec[IDX_CBC] = sw_clr[IDX_CBC+1] | auto_clr;
    end

    ptf_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .glob_i    (glob),
        .flag_i    (flags),
        .sw_clr_o  (sw_clr),
        .sel_o     (sel),
        .rd_data_o (rd_data_o)
    );

    ptf_autoclr u_autoclr (
        .sel_i     (sel),
        .tb_zero_i (tb_zero_i),
        .tb_prd_i  (tb_prd_i),
        .clr_o     (auto_clr)
    );

    ptf_flag_bank #(.N(NUM_FLAG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags)
    );

    ptf_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_flag_i (|flags),
        .clr_glob_i (sw_clr[0]),
        .glob_o     (glob),
        .irq_o      (irq_o)
    );

    AST_OST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[IDX_OST] && !sw_clr[IDX_OST+1]) |=> flags[IDX_OST]); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == ADDR_CLR || rd_addr_i == ADDR_CLR_MR) |-> (rd_data_o[SEL_LSB-1:0] == '0)); // R3
endmodule

// File: tb/tb_pwm_trip_flag_ctrl.sv
module tb_pwm_trip_flag_ctrl;
    import ptf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cbc_trip_i = 1'b0, ost_trip_i = 1'b0;
    logic [3:0]  dc_evt_i = '0;
    logic        tb_zero_i = 1'b0, tb_prd_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0, rd_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int checks = 0, fails = 0, irq_cnt = 0;

    always #4 clk = ~clk;

    pwm_trip_flag_ctrl dut (.*);

    always @(posedge clk) begin
        #2;
        if (irq_o) irq_cnt++;
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic strobe(logic c, logic o, logic [3:0] e, logic z, logic p);
        cbc_trip_i = c; ost_trip_i = o; dc_evt_i = e; tb_zero_i = z; tb_prd_i = p;
        tick();
        cbc_trip_i = 0; ost_trip_i = 0; dc_evt_i = '0; tb_zero_i = 0; tb_prd_i = 0;
    endtask

    task automatic set_bit(int i);
        strobe(i == 1, i == 2, (i >= 3) ? 4'(1 << (i - 3)) : 4'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int c0;
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(ADDR_STATUS, d); chk("R1 status", d, 16'h0);
        rd(ADDR_CLR, d);    chk("R1 clr", d, 16'h0);
        rd(ADDR_CLR_MR, d); chk("R1 mirror", d, 16'h0);
        rd(2'd3, d);        chk("R1 unused", d, 16'h0);
        chk("R1 irq", {15'b0, irq_o}, 16'h0);

        // R2/R3/R4/R7/R9 per-flag sweep
        for (int i = 1; i <= 6; i++) begin
            c0 = irq_cnt;
            set_bit(i);
            tick(3);
            rd(ADDR_STATUS, d); chk("R2 set position", d, 16'((1 << i) | 1));
            chk("R7 one pulse", 16'(irq_cnt - c0), 16'd1);
            wr(ADDR_CLR, 16'h0000);
            tick(2);
            rd(ADDR_STATUS, d); chk("R3 zero write no effect", d, 16'((1 << i) | 1));
            rd(ADDR_CLR, d);    chk("R3 clear bits read 0", d, 16'h0);
            wr((i % 2) ? ADDR_CLR : ADDR_CLR_MR, 16'(1 << i));
            tick(2);
            rd(ADDR_STATUS, d); chk("R4 clear via primary/mirror", d, 16'h1);
            wr(ADDR_CLR, 16'h0001);
            tick(3);
            rd(ADDR_STATUS, d); chk("R9 all clear", d, 16'h0);
            chk("R9 no extra pulse", 16'(irq_cnt - c0), 16'd1);
        end

        // R8 / R9 rearm
        c0 = irq_cnt;
        strobe(0, 1, 4'b0000, 0, 0);
        tick(3);
        strobe(0, 0, 4'b1000, 0, 0);
        tick(3);
        chk("R8 no pulse while global set", 16'(irq_cnt - c0), 16'd1);
        rd(ADDR_STATUS, d); chk("R2 ost+B2", d, 16'h0045);
        wr(ADDR_CLR_MR, 16'h0001);
        tick(3);
        chk("R9 rearm pulse", 16'(irq_cnt - c0), 16'd2);
        rd(ADDR_STATUS, d); chk("R9 flags kept", d, 16'h0045);
        wr(ADDR_CLR, 16'h007F);
        tick(6);
        rd(ADDR_STATUS, d); chk("R9 full clear", d, 16'h0);
        chk("R9 silent after full clear", 16'(irq_cnt - c0), 16'd2);

        // R5/R10 select sweep
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic z, p, cleared;
                z = c[0]; p = c[1];
                wr((c % 2) ? ADDR_CLR_MR : ADDR_CLR, 16'(s << 14));
                rd(ADDR_CLR, d);    chk("R5 select readback", d, 16'(s << 14));
                rd(ADDR_CLR_MR, d); chk("R4 select mirror readback", d, 16'(s << 14));
                strobe(1, 1, 4'b1111, 0, 0);
                tick(3);
                strobe(0, 0, 4'b0000, z, p);
                tick();
                cleared = (s == 0 && z) || (s == 1 && p) || (s == 2 && (z || p));
                rd(ADDR_STATUS, d);
                chk("R5 auto clear select", {15'b0, d[1]}, {15'b0, !cleared});
                chk("R10 ost and events untouched", {9'b0, d[6:2], 2'b0}, 16'h007C);
                wr(ADDR_CLR, 16'(s << 14) | 16'h007F);
                tick(3);
            end
        end

        // R6 set wins
        wr(ADDR_CLR, 16'hC000);
        strobe(1, 0, 4'b0000, 0, 0);
        tick(3);
        cbc_trip_i = 1'b1;
        wr(ADDR_CLR, 16'hC002);
        cbc_trip_i = 1'b0;
        tick();
        rd(ADDR_STATUS, d); chk("R6 set beats sw clear", {15'b0, d[1]}, 16'h1);
        wr(ADDR_CLR, 16'h0002);
        tick();
        rd(ADDR_STATUS, d); chk("R3 cbc cleared", {15'b0, d[1]}, 16'h0);
        strobe(1, 0, 4'b0000, 1, 0);
        tick();
        rd(ADDR_STATUS, d); chk("R6 set beats auto clear", {15'b0, d[1]}, 16'h1);
        dc_evt_i = 4'b0001;
        wr(ADDR_CLR_MR, 16'h0008);
        dc_evt_i = 4'b0000;
        tick();
        rd(ADDR_STATUS, d); chk("R6 event set beats clear", {15'b0, d[3]}, 16'h1);
        wr(ADDR_CLR, 16'h007F);
        tick(3);
        rd(ADDR_STATUS, d); chk("R3 final clear", d, 16'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule